// File: doc/BRIEF.md
# Soft-Decision Convolutional Decoder (K=7, Rate 1/2)

This block recovers the most likely information bit stream from a rate-1/2 convolutional code with constraint length 7. Each received symbol carries two signed soft values, one per coded bit, as delivered by a QPSK demodulator. For every symbol the block forms four branch metrics from the squared Euclidean distance to the four ideal constellation points. It then runs add-compare-select over all 64 trellis states and writes the 64 survivor decisions into a banked path memory. A traceback that is 64 steps deep, started from the best current state, yields one decided bit per symbol.

Path metrics are renormalized when the smallest one crosses a threshold, so their width stays fixed over unbounded streams. A padding shift line after the traceback makes the delay from a symbol to its decoded bit exactly 256 symbols, whatever the spacing of the input strobes. The decoder advances only on input strobes, and each strobe produces exactly one output slot.

Top module: `viterbi_sd_decoder`

## Requirements
- R1: The code follows this definition. Let b be the current input bit and h the previous six input bits, most recent first, and form the 7-bit vector {b, h} with b as the MSB. The I coded bit is the XOR of that vector masked by octal 171, and the Q coded bit is the same with octal 133. The encoder starts from the all-zero history.
- R2: Soft inputs are 6-bit two's complement. Coded bit 0 has ideal value +31 and coded bit 1 has ideal value -32. The sym_i input carries the octal-171 bit and sym_q carries the octal-133 bit. A noise-free stream at the ideal values decodes without error.
- R3: Branch metrics are squared Euclidean distances, so an error-free stream decodes exactly at any mix of signal amplitudes between 4 and 31.
- R4: Isolated symbol errors are corrected. With one I component sign-inverted every 37 symbols at amplitude 20, the output still equals the transmitted bits.
- R5: bit_vld and bit_out update on the clock edge that accepts a symbol. The slot produced when symbol number m (counted from 0 after reset) is accepted carries information bit m-256, and the first valid slot is m = 256.
- R6: bit_vld and bit_out are 0 during reset, and bit_vld stays 0 for the first 256 accepted symbols after every reset.
- R7: bit_vld is high only in the cycle after sym_vld was high. With no strobe, bit_out holds and the decoder state does not advance, so idle gaps of any length leave the decoded stream unchanged.
- R8: When the smallest path metric reaches 2^(PM_W-2), that amount is subtracted from every state metric before the next add. No metric overflows, and decoding stays exact over thousands of symbols at low amplitude.
- R9: Reset places state 0 at metric 0 and every other state at 2^(PM_W-3). A reset in mid-stream restarts decoding, and the first bits after it decode correctly for an encoder restarted from the zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_vld | input | 1 | Symbol strobe, one received symbol per high cycle |
| sym_i | input | SOFT_W | Signed soft value of the octal-171 coded bit |
| sym_q | input | SOFT_W | Signed soft value of the octal-133 coded bit |
| bit_vld | output | 1 | Decoded bit valid |
| bit_out | output | 1 | Decoded information bit |

## Verification
The bench aims at the latency boundary: symbol 255 must give no valid slot and symbol 256 must give bit 0. A decoder with an off-by-one in its padding line or its traceback would emit the wrong bit at every position. Long runs at amplitude 12 push the smallest metric through the renormalization threshold many times. A wrong offset or a missed carry there corrupts survivor selection and the output diverges. Spaced sign inversions and constant or alternating patterns stress survivor selection and the all-ones end of the trellis. A mid-stream reset checks that valid drops again and that the metrics restart from state 0; a stale metric would mis-decode the first bits.

// File: rtl/vit_pkg.sv
package vit_pkg;

   // Two coded bits for one trellis branch: {I bit, Q bit}.
   typedef logic [1:0] code_pair_t;

   function automatic code_pair_t branch_code(input int unsigned in_bit,
                                              input int unsigned prev_st,
                                              input int unsigned hist_len,
                                              input logic [15:0]  poly_i,
                                              input logic [15:0]  poly_q);
      logic [15:0] vec;
      vec = 16'((in_bit << hist_len) | prev_st);
      return {^(vec & poly_i), ^(vec & poly_q)};
   endfunction

endpackage

// File: rtl/vit_branch_metric.sv
module vit_branch_metric #(
   parameter int SOFT_W = 6,
   parameter int BM_W   = 2 * SOFT_W + 3
)(
   input  logic [SOFT_W-1:0] soft_i,
   input  logic [SOFT_W-1:0] soft_q,
   output logic [BM_W-1:0]   bm [4]
);
   localparam int DW      = SOFT_W + 1;
   localparam int SQ_W    = 2 * DW;
   localparam int PT_HI   = (1 << (SOFT_W - 1)) - 1;
   localparam int PT_LO   = -(1 << (SOFT_W - 1));

   logic signed [DW-1:0] ext_i, ext_q;
   assign ext_i = DW'($signed(soft_i));
   assign ext_q = DW'($signed(soft_q));

   // bm index is {I coded bit, Q coded bit}; coded 0 -> PT_HI, coded 1 -> PT_LO
   for (genvar c = 0; c < 4; c++) begin : g_pt
      localparam logic [1:0] CC = 2'(c);
      localparam logic signed [DW-1:0] REF_I = CC[1] ? DW'(PT_LO) : DW'(PT_HI);
      localparam logic signed [DW-1:0] REF_Q = CC[0] ? DW'(PT_LO) : DW'(PT_HI);
      logic signed [DW-1:0]   di, dq;
      logic signed [SQ_W-1:0] xi, xq, sqi, sqq;
      always_comb begin
         di  = ext_i - REF_I;
         dq  = ext_q - REF_Q;
         xi  = SQ_W'(di);
         xq  = SQ_W'(dq);
         sqi = xi * xi;
         sqq = xq * xq;
         bm[c] = BM_W'($unsigned(sqi)) + BM_W'($unsigned(sqq));
      end
   end
endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array
   import vit_pkg::*;
#(
   parameter int             K     = 7,
   parameter logic [K-1:0]   GEN_I = 7'o171,
   parameter logic [K-1:0]   GEN_Q = 7'o133,
   parameter int             BM_W  = 15,
   parameter int             PM_W  = 20,
   localparam int            SW    = K - 1,
   localparam int            NS    = 1 << SW
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic [BM_W-1:0] bm [4],
   output logic [NS-1:0]   dec_new,
   output logic [SW-1:0]   best_st,
   output logic [PM_W-1:0] min_pm,
   output logic            norm_hit,
   output logic            carry_any
);
   localparam logic [PM_W-1:0] THRESH   = PM_W'(1) << (PM_W - 2);
   localparam logic [PM_W-1:0] START_PM = PM_W'(1) << (PM_W - 3);
   localparam int              HALF     = NS / 2;

   logic [PM_W-1:0] pm_q [NS];
   logic [PM_W-1:0] pm_d [NS];
   logic [NS-1:0]   carry;
   logic [PM_W-1:0] offset;

   // best state and smallest metric of the stored metrics
   always_comb begin
      min_pm  = pm_q[0];
      best_st = '0;
      for (int s = 1; s < NS; s++) begin
         if (pm_q[s] < min_pm) begin
            min_pm  = pm_q[s];
            best_st = SW'(s);
         end
      end
   end

   assign norm_hit = (min_pm >= THRESH);
   assign offset   = norm_hit ? THRESH : '0;

   // next state s = {b, p[SW-1:1]}; its predecessors differ only in the LSB
   for (genvar s = 0; s < NS; s++) begin : g_acs
      localparam int         P0 = (s % HALF) * 2;
      localparam int         P1 = P0 + 1;
      localparam int         IB = s / HALF;
      localparam code_pair_t C0 = branch_code(IB, P0, SW, 16'(GEN_I), 16'(GEN_Q));
      localparam code_pair_t C1 = branch_code(IB, P1, SW, 16'(GEN_I), 16'(GEN_Q));
      logic [PM_W:0] sum0, sum1, win;
      logic          pick;
      always_comb begin
         sum0 = {1'b0, pm_q[P0] - offset} + (PM_W+1)'(bm[C0]);
         sum1 = {1'b0, pm_q[P1] - offset} + (PM_W+1)'(bm[C1]);
         pick = (sum1 < sum0);
         win  = pick ? sum1 : sum0;
      end
      assign dec_new[s] = pick;
      assign pm_d[s]    = win[PM_W-1:0];
      assign carry[s]   = win[PM_W];
   end

   assign carry_any = |carry;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NS; s++) pm_q[s] <= (s == 0) ? '0 : START_PM;
      end else if (step) begin
         for (int s = 0; s < NS; s++) pm_q[s] <= pm_d[s];
      end
   end
endmodule

// File: rtl/vit_path_bank.sv
module vit_path_bank #(
   parameter int NS   = 64,
   parameter int ROWS = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic [NS-1:0]      din,
   output logic [ROWS*NS-1:0] rows_flat
);
   // row 0 (lowest slice) holds the newest decision word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rows_flat <= '0;
      end else if (step) begin
         if (ROWS > 1) rows_flat <= {rows_flat[(ROWS-1)*NS-1:0], din};
         else          rows_flat <= (ROWS*NS)'(din);
      end
   end
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback #(
   parameter int SW    = 6,
   parameter int DEPTH = 64,
   localparam int NS   = 1 << SW
)(
   input  logic [DEPTH*NS-1:0] hist_flat,
   input  logic [SW-1:0]       start_st,
   output logic                tb_bit
);
   logic [SW-1:0] st;
   always_comb begin
      st = start_st;
      for (int j = 0; j < DEPTH; j++) begin
         st = {st[SW-2:0], hist_flat[j*NS + int'(st)]};
      end
      tb_bit = st[SW-1];
   end
endmodule

// File: rtl/viterbi_sd_decoder.sv
module viterbi_sd_decoder #(
   parameter int           SOFT_W   = 6,
   parameter int           K        = 7,
   parameter logic [K-1:0] GEN_I    = 7'o171,
   parameter logic [K-1:0] GEN_Q    = 7'o133,
   parameter int           TB_DEPTH = 64,
   parameter int           N_BANK   = 4,
   parameter int           LATENCY  = 256,
   parameter int           PM_W     = 20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sym_vld,
   input  logic [SOFT_W-1:0] sym_i,
   input  logic [SOFT_W-1:0] sym_q,
   output logic              bit_vld,
   output logic              bit_out
);
   localparam int SW        = K - 1;
   localparam int NS        = 1 << SW;
   localparam int BM_W      = 2 * SOFT_W + 3;
   localparam int BM_MAX    = 2 * ((1 << SOFT_W) - 1) * ((1 << SOFT_W) - 1);
   localparam int BANK_ROWS = TB_DEPTH / N_BANK;
   localparam int DLY       = LATENCY - TB_DEPTH - 1;
   localparam int CNT_W     = $clog2(LATENCY + 1);

   if (K < 3 || K > 16) begin : g_bad_k
      $error("constraint length out of range");
   end
   if (SOFT_W < 2) begin : g_bad_soft
      $error("soft width too small");
   end
   if (N_BANK < 1 || TB_DEPTH % N_BANK != 0) begin : g_bad_bank
      $error("traceback depth must split evenly into banks");
   end
   if (LATENCY < TB_DEPTH + 3) begin : g_bad_lat
      $error("latency too short for traceback depth");
   end
   if (K * BM_MAX >= (1 << (PM_W - 3))) begin : g_bad_pm
      $error("path metric width too small for metric spread");
   end

   logic [BM_W-1:0]        bm [4];
   logic [NS-1:0]          dec_new;
   logic [SW-1:0]          best_st;
   logic [PM_W-1:0]        min_pm;
   logic                   norm_hit;
   logic                   carry_any;
   logic [TB_DEPTH*NS-1:0] hist_flat;
   logic                   tb_bit;
   logic [DLY-1:0]         dly_q;
   logic [CNT_W-1:0]       sym_cnt;

   vit_branch_metric #(.SOFT_W(SOFT_W), .BM_W(BM_W)) u_bm (
      .soft_i (sym_i),
      .soft_q (sym_q),
      .bm     (bm)
   );

   vit_acs_array #(.K(K), .GEN_I(GEN_I), .GEN_Q(GEN_Q), .BM_W(BM_W), .PM_W(PM_W)) u_acs (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (sym_vld),
      .bm        (bm),
      .dec_new   (dec_new),
      .best_st   (best_st),
      .min_pm    (min_pm),
      .norm_hit  (norm_hit),
      .carry_any (carry_any)
   );

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      localparam int LO = b * BANK_ROWS * NS;
      logic [NS-1:0] bank_in;
      if (b == 0) begin : g_head
         assign bank_in = dec_new;
      end else begin : g_chain
         assign bank_in = hist_flat[LO-NS +: NS];
      end
      vit_path_bank #(.NS(NS), .ROWS(BANK_ROWS)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .step      (sym_vld),
         .din       (bank_in),
         .rows_flat (hist_flat[LO +: BANK_ROWS*NS])
      );
   end

   vit_traceback #(.SW(SW), .DEPTH(TB_DEPTH)) u_tb (
      .hist_flat (hist_flat),
      .start_st  (best_st),
      .tb_bit    (tb_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_q   <= '0;
         sym_cnt <= '0;
         bit_vld <= 1'b0;
         bit_out <= 1'b0;
      end else begin
         bit_vld <= sym_vld && (sym_cnt == CNT_W'(LATENCY));
         if (sym_vld) begin
            dly_q   <= {dly_q[DLY-2:0], tb_bit};
            bit_out <= dly_q[DLY-1];
            if (sym_cnt != CNT_W'(LATENCY)) sym_cnt <= sym_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/vit_checker.sv
module vit_checker #(
   parameter int LATENCY = 256,
   parameter int PM_W    = 20
)(
   input logic            clk,
   input logic            rst_n,
   input logic            sym_vld,
   input logic            bit_vld,
   input logic            bit_out,
   input logic [PM_W-1:0] min_pm,
   input logic            norm_hit,
   input logic            carry_any
);
   localparam logic [PM_W:0] LIMIT = (PM_W+1)'(1) << (PM_W - 1);

   int acc_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) acc_cnt <= 0;
      else if (sym_vld && acc_cnt < LATENCY) acc_cnt <= acc_cnt + 1;
   end

   AST_NO_EARLY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && acc_cnt < LATENCY) |=> !bit_vld);                        // R6
   AST_VLD_NEEDS_SYM: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |-> $past(sym_vld));                                          // R7
   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_vld |=> $stable(bit_out));                                       // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_any);                                                          // R8
   AST_MIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, min_pm} < LIMIT);                                              // R8
   AST_NORM_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && norm_hit) |=> min_pm < $past(min_pm));                    // R8
   AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (min_pm == '0));                                     // R9
endmodule

bind viterbi_sd_decoder vit_checker #(.LATENCY(LATENCY), .PM_W(PM_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .sym_vld   (sym_vld),
   .bit_vld   (bit_vld),
   .bit_out   (bit_out),
   .min_pm    (min_pm),
   .norm_hit  (norm_hit),
   .carry_any (carry_any)
);

// File: tb/viterbi_sd_decoder_tb_top.sv
module viterbi_sd_decoder_tb_top;
   localparam int LAT = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_vld = 1'b0;
   logic [5:0] sym_i = '0;
   logic [5:0] sym_q = '0;
   logic       bit_vld, bit_out;

   always #4 clk = ~clk;

   viterbi_sd_decoder dut_i (
      .clk (clk), .rst_n (rst_n), .sym_vld (sym_vld),
      .sym_i (sym_i), .sym_q (sym_q), .bit_vld (bit_vld), .bit_out (bit_out)
   );

   int         checks = 0, errors = 0;
   int         m = 0;
   logic [5:0] enc_st = '0;
   logic       tx [16384];
   logic [15:0] lfsr = 16'hACE1;
   bit         done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s m=%0d actual=%0d expected=%0d", req, m, act, exp);
      end
   endtask

   function automatic logic next_rand();
      lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
      return lfsr[0];
   endfunction

   // amp 0: ideal points +31/-32; otherwise +amp/-amp
   task automatic send(input logic b, input int amp, input bit flip, input string req);
      logic [6:0] v;
      int vi, vq;
      v = {b, enc_st};
      enc_st = v[6:1];
      vi = (^(v & 7'o171)) ? ((amp == 0) ? -32 : -amp) : ((amp == 0) ? 31 : amp);
      vq = (^(v & 7'o133)) ? ((amp == 0) ? -32 : -amp) : ((amp == 0) ? 31 : amp);
      if (flip) vi = -vi;
      sym_i   = 6'(vi);
      sym_q   = 6'(vq);
      sym_vld = 1'b1;
      tx[m]   = b;
      @(negedge clk);
      sym_vld = 1'b0;
      if (m < LAT)
         chk(bit_vld === 1'b0, "R6", int'(bit_vld), 0);
      else if (m == LAT)
         chk(bit_vld === 1'b1 && bit_out === tx[0], "R5",
             int'({bit_vld, bit_out}), int'({1'b1, tx[0]}));
      else
         chk(bit_vld === 1'b1 && bit_out === tx[m-LAT], req,
             int'({bit_vld, bit_out}), int'({1'b1, tx[m-LAT]}));
      m++;
   endtask

   task automatic idle(input int n);
      logic held;
      held = bit_out;
      repeat (n) begin
         @(negedge clk);
         chk(bit_vld === 1'b0 && bit_out === held, "R7",
             int'({bit_vld, bit_out}), int'({1'b0, held}));
      end
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      sym_vld = 1'b0;
      repeat (3) @(negedge clk);
      chk(bit_vld === 1'b0 && bit_out === 1'b0, "R6",
          int'({bit_vld, bit_out}), 0);
      rst_n  = 1'b1;
      enc_st = '0;
      m      = 0;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R2: ideal points, random bits, back to back
      for (int k = 0; k < 500; k++) send(next_rand(), 0, 1'b0, "R2");
      // R1: structured patterns hit the all-ones and alternating paths
      for (int k = 0; k < 200; k++) send(1'b1, 0, 1'b0, "R1");
      for (int k = 0; k < 200; k++) send(1'(k % 2), 0, 1'b0, "R1");
      for (int k = 0; k < 200; k++) send(1'b0, 0, 1'b0, "R1");
      // R3: amplitudes varying per symbol
      for (int k = 0; k < 400; k++) send(next_rand(), 4 + (k * 7) % 28, 1'b0, "R3");
      // R8: low amplitude long run with idle gaps (R7)
      for (int k = 0; k < 3000; k++) begin
         send(next_rand(), 12, 1'b0, "R8");
         if (k % 5 == 4) idle(2);
      end
      // R4: spaced sign inversions
      for (int k = 0; k < 800; k++) send(next_rand(), 20, (k % 37) == 18, "R4");
      // R9: mid-stream reset and restart
      do_reset();
      for (int k = 0; k < 400; k++) send(next_rand(), 0, 1'b0, "R9");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule